// File: doc/BRIEF.md
# Banked Exception Vector Address Generator

This block forms the fetch address for a taken exception in a core that has a secure world, a non-secure world and a hypervisor level above the non-secure guest kernel. It keeps three vector base registers: one for the guest kernel and user levels, one for hypervisor mode and one for monitor mode. A control bit turns virtualization support on. These four items sit behind a small register-access port. Each access is checked against the mode that issues it. An access without the right is dropped and reported as an undefined-instruction fault.

When an exception request arrives, the block selects the target mode and the matching base. It adds the vector offset for the exception type. One cycle later it presents the address and the new mode. When virtualization is on, offset 0x14 carries the hypervisor call. When it is off, that slot is unused and a hypervisor call is handled as an undefined instruction. Every entry into hypervisor mode also latches a syndrome word, in the same cycle as the vector output. The syndrome holds a class code and instruction detail for the hypervisor's emulation code.

Top module: `exc_vector_unit`

## Requirements
- R1: After a synchronous active-low reset, all three bases read as zero, virtualization is off, `vec_valid`, `csr_fault` and `csr_rdata` are zero, and `syndrome` is zero.
- R2: `exc_type` codes: 0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 hypervisor call, 6 IRQ, 7 FIQ. For every code except 5, the cycle after `exc_req`, `vec_valid` is 1 and `vec_addr` is the selected base plus 4 times the code (0x00, 0x04, 0x08, 0x0C, 0x10, 0x18, 0x1C).
- R3: A hypervisor call with virtualization on, issued in non-secure kernel mode, yields `vec_mode` hyp (2) and `vec_addr` = hyp base + 0x14, whatever `exc_target` is.
- R4: A hypervisor call in any other case (virtualization off, secure, or a mode other than kernel) is handled as undefined instruction: offset 0x04 at the requested target.
- R5: Mode codes are 0 user, 1 kernel, 2 hyp, 3 monitor. A target of user or kernel resolves to kernel mode with the guest base. A target of monitor uses the monitor base. A target of hyp uses the hyp base when virtualization is on, and otherwise resolves to kernel with the guest base.
- R6: `csr_sel` 2 (monitor base) is accessible only when `cur_mode` is monitor.
- R7: `csr_sel` 1 (hyp base) is accessible only in hyp or monitor mode.
- R8: `csr_sel` 0 (guest base) is accessible in every mode except user.
- R9: `csr_sel` 3 is the control word, with bit 0 = virtualization enable. It is accessible only when `cur_secure` is 1 and the mode is kernel or monitor.
- R10: A denied read or write leaves all state unchanged. On the next cycle it gives `csr_fault` = 1 for one cycle and `csr_rdata` = 0. A permitted read returns the pre-access value on the next cycle.
- R11: Written bases have bits [4:0] forced to zero, so every base is 32-byte aligned.
- R12: On every entry into hyp mode, `syndrome` is loaded in the same cycle as `vec_addr`. It takes the value {class, `exc_iss`}, where class is 0x12 for a hypervisor call and `exc_class` otherwise, and the class sits in bits [31:26]. At all other times `syndrome` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_mode | input | 2 | Mode of the issuing code (0 user, 1 kernel, 2 hyp, 3 monitor) |
| cur_secure | input | 1 | 1 when the issuing code runs in the secure world |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_sel | input | 2 | Register select: 0 guest base, 1 hyp base, 2 monitor base, 3 control |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, one cycle after the read |
| csr_fault | output | 1 | One-cycle undefined-instruction pulse for a denied access |
| exc_req | input | 1 | Exception taken this cycle |
| exc_type | input | 3 | Exception type code |
| exc_target | input | 2 | Mode that should take the exception |
| exc_class | input | 6 | Syndrome class for a trap into hyp |
| exc_iss | input | 26 | Instruction-specific syndrome detail |
| vec_valid | output | 1 | Vector output valid |
| vec_addr | output | 32 | Exception fetch address |
| vec_mode | output | 2 | Mode entered |
| syndrome | output | 32 | Hyp-entry syndrome word |

## Verification
The exception path is driven with all eight type codes across every mode, world and target combination, with virtualization both off and on. This separates the plain offset map from the hypervisor-call slot and from the fallback to undefined. Register accesses are issued from every mode against every select with random data. Denied and permitted paths are told apart through read-back, fault pulses and later vector addresses. Directed cases cover all-ones writes for alignment, a hyp target while virtualization is off, and syndrome retention between hyp entries.

// File: rtl/exc_vec_pkg.sv
// Shared codes for the exception vector unit.
// Assumes 2-bit mode codes and 3-bit exception type codes.
package exc_vec_pkg;
    localparam logic [1:0] MD_USER = 2'd0;
    localparam logic [1:0] MD_KERN = 2'd1;
    localparam logic [1:0] MD_HYP  = 2'd2;
    localparam logic [1:0] MD_MON  = 2'd3;

    localparam logic [1:0] SEL_GUEST = 2'd0;
    localparam logic [1:0] SEL_HYP   = 2'd1;
    localparam logic [1:0] SEL_MON   = 2'd2;
    localparam logic [1:0] SEL_CTL   = 2'd3;

    localparam logic [2:0] EX_UNDEF = 3'd1;
    localparam logic [2:0] EX_HVC   = 3'd5;
endpackage

// File: rtl/vbar_bank.sv
// Holds the three vector bases and the virtualization enable bit.
// Every register access is checked against the issuing mode and world.
// A denied access changes nothing and raises a one-cycle fault.
// Assumes a synchronous active-low reset.
module vbar_bank
    import exc_vec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_mode,
    input  logic              cur_secure,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [1:0]        csr_sel,
    input  logic [ADDR_W-1:0] csr_wdata,
    output logic [ADDR_W-1:0] csr_rdata,
    output logic              csr_fault,
    output logic [ADDR_W-1:0] guest_base,
    output logic [ADDR_W-1:0] hyp_base,
    output logic [ADDR_W-1:0] mon_base,
    output logic              virt_en
);
    localparam int NBASE = 3;

    logic              allowed;
    logic              access;
    logic [ADDR_W-1:0] base_q [NBASE];
    logic [ADDR_W-1:0] rd_val;

    // Decide whether the issuing mode may touch the selected register.
    always_comb begin
        unique case (csr_sel)
            SEL_GUEST: allowed = (cur_mode != MD_USER);
            SEL_HYP:   allowed = (cur_mode == MD_HYP) || (cur_mode == MD_MON);
            SEL_MON:   allowed = (cur_mode == MD_MON);
            default:   allowed = cur_secure && ((cur_mode == MD_KERN) || (cur_mode == MD_MON));
        endcase
    end

    assign access = csr_wr || csr_rd;

    for (genvar i = 0; i < NBASE; i++) begin : g_base
        // Hold one base register, always stored aligned.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[i] <= '0;
            else if (csr_wr && allowed && (csr_sel == 2'(i)))
                base_q[i] <= {csr_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    // Hold the virtualization enable bit, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            virt_en <= 1'b0;
        else if (csr_wr && allowed && (csr_sel == SEL_CTL))
            virt_en <= csr_wdata[0];
    end

    // Select the value a read returns.
    always_comb begin
        if (csr_sel == SEL_CTL)
            rd_val = {{(ADDR_W-1){1'b0}}, virt_en};
        else
            rd_val = base_q[csr_sel];
    end

    // Register the read data and the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_rdata <= '0;
            csr_fault <= 1'b0;
        end else begin
            csr_rdata <= (csr_rd && allowed) ? rd_val : '0;
            csr_fault <= access && !allowed;
        end
    end

    assign guest_base = base_q[SEL_GUEST];
    assign hyp_base   = base_q[SEL_HYP];
    assign mon_base   = base_q[SEL_MON];

    a_r6_mon_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel == SEL_MON && cur_mode != MD_MON) |=> $stable(mon_base));
    a_r7_hyp_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel == SEL_HYP && (cur_mode == MD_USER || cur_mode == MD_KERN)) |=> $stable(hyp_base));
    a_r9_ctl_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel == SEL_CTL && !cur_secure) |=> $stable(virt_en));
    a_r10_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        csr_fault |-> (csr_rdata == '0));
endmodule

// File: rtl/vec_route.sv
// Combinational routing of one exception request.
// Resolves the target mode, picks the base, adds the type offset
// and chooses the syndrome class. Assumes offsets are 4 x type code.
module vec_route
    import exc_vec_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CLASS_W = 6,
    parameter logic [CLASS_W-1:0] HVC_CLASS = 6'h12
) (
    input  logic [1:0]         cur_mode,
    input  logic               cur_secure,
    input  logic [2:0]         exc_type,
    input  logic [1:0]         exc_target,
    input  logic [CLASS_W-1:0] exc_class,
    input  logic               virt_en,
    input  logic [ADDR_W-1:0]  guest_base,
    input  logic [ADDR_W-1:0]  hyp_base,
    input  logic [ADDR_W-1:0]  mon_base,
    output logic [ADDR_W-1:0]  addr,
    output logic [1:0]         mode,
    output logic               hyp_entry,
    output logic [CLASS_W-1:0] syn_class
);
    logic       hvc_ok;
    logic [2:0] eff_type;
    logic [ADDR_W-1:0] base;

    // Decide whether a hypervisor call is honoured or demoted.
    always_comb begin
        hvc_ok   = (exc_type == EX_HVC) && virt_en && (cur_mode == MD_KERN) && !cur_secure;
        eff_type = ((exc_type == EX_HVC) && !hvc_ok) ? EX_UNDEF : exc_type;
    end

    // Resolve the mode that takes the exception and its base.
    always_comb begin
        if (hvc_ok)
            mode = MD_HYP;
        else if (exc_target == MD_MON)
            mode = MD_MON;
        else if (exc_target == MD_HYP && virt_en)
            mode = MD_HYP;
        else
            mode = MD_KERN;
        unique case (mode)
            MD_HYP:  base = hyp_base;
            MD_MON:  base = mon_base;
            default: base = guest_base;
        endcase
    end

    assign addr      = base + {{(ADDR_W-5){1'b0}}, eff_type, 2'b00};
    assign hyp_entry = (mode == MD_HYP);
    assign syn_class = hvc_ok ? HVC_CLASS : exc_class;
endmodule

// File: rtl/syn_capture.sv
// Syndrome register: loads on each hyp entry and holds otherwise.
// Assumes the load strobe is already qualified with the request.
module syn_capture #(
    parameter int SYN_W   = 32,
    parameter int CLASS_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [CLASS_W-1:0]       cls,
    input  logic [SYN_W-CLASS_W-1:0] iss,
    output logic [SYN_W-1:0]         syndrome
);
    // Capture class and detail on hyp entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            syndrome <= '0;
        else if (load)
            syndrome <= {cls, iss};
    end
endmodule

// File: rtl/exc_vector_unit.sv
// Top of the banked exception vector address generator.
// Combines the base bank, the router and the syndrome register,
// and registers the vector outputs one cycle after a request.
// Assumes a synchronous active-low reset and a 4-space style.
module exc_vector_unit
    import exc_vec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5,
    parameter int SYN_W      = 32,
    parameter int CLASS_W    = 6,
    parameter logic [CLASS_W-1:0] HVC_CLASS = 6'h12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cur_mode,
    input  logic                     cur_secure,
    input  logic                     csr_wr,
    input  logic                     csr_rd,
    input  logic [1:0]               csr_sel,
    input  logic [ADDR_W-1:0]        csr_wdata,
    output logic [ADDR_W-1:0]        csr_rdata,
    output logic                     csr_fault,
    input  logic                     exc_req,
    input  logic [2:0]               exc_type,
    input  logic [1:0]               exc_target,
    input  logic [CLASS_W-1:0]       exc_class,
    input  logic [SYN_W-CLASS_W-1:0] exc_iss,
    output logic                     vec_valid,
    output logic [ADDR_W-1:0]        vec_addr,
    output logic [1:0]               vec_mode,
    output logic [SYN_W-1:0]         syndrome
);
    logic [ADDR_W-1:0]  guest_base, hyp_base, mon_base;
    logic               virt_en;
    logic [ADDR_W-1:0]  r_addr;
    logic [1:0]         r_mode;
    logic               r_hyp;
    logic [CLASS_W-1:0] r_class;

    vbar_bank #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .cur_secure(cur_secure),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_fault(csr_fault),
        .guest_base(guest_base), .hyp_base(hyp_base), .mon_base(mon_base),
        .virt_en(virt_en)
    );

    vec_route #(.ADDR_W(ADDR_W), .CLASS_W(CLASS_W), .HVC_CLASS(HVC_CLASS)) u_route (
        .cur_mode(cur_mode), .cur_secure(cur_secure), .exc_type(exc_type),
        .exc_target(exc_target), .exc_class(exc_class), .virt_en(virt_en),
        .guest_base(guest_base), .hyp_base(hyp_base), .mon_base(mon_base),
        .addr(r_addr), .mode(r_mode), .hyp_entry(r_hyp), .syn_class(r_class)
    );

    syn_capture #(.SYN_W(SYN_W), .CLASS_W(CLASS_W)) u_syn (
        .clk(clk), .rst_n(rst_n), .load(exc_req && r_hyp),
        .cls(r_class), .iss(exc_iss), .syndrome(syndrome)
    );

    // Register the vector address and new mode for one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
            vec_mode  <= MD_KERN;
        end else begin
            vec_valid <= exc_req;
            if (exc_req) begin
                vec_addr <= r_addr;
                vec_mode <= r_mode;
            end
        end
    end

    a_r3_hvc_enters_hyp: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_type == EX_HVC && virt_en && cur_mode == MD_KERN && !cur_secure)
        |=> (vec_valid && vec_mode == MD_HYP));
    a_r5_no_hyp_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !virt_en) |=> (vec_mode != MD_HYP));
    a_r12_syn_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req && r_hyp) |=> $stable(syndrome));
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> vec_valid);
endmodule

// File: tb/exc_vector_unit_bench.sv
`timescale 1ns/1ps
module exc_vector_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    logic        cur_secure = 1'b0;
    logic        csr_wr = 1'b0, csr_rd = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic [31:0] csr_wdata = 32'd0;
    logic [31:0] csr_rdata;
    logic        csr_fault;
    logic        exc_req = 1'b0;
    logic [2:0]  exc_type = 3'd0;
    logic [1:0]  exc_target = 2'd0;
    logic [5:0]  exc_class = 6'd0;
    logic [25:0] exc_iss = 26'd0;
    logic        vec_valid;
    logic [31:0] vec_addr;
    logic [1:0]  vec_mode;
    logic [31:0] syndrome;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_base [3];
    logic        m_ve;
    logic [31:0] m_syn;

    exc_vector_unit u_exc_vector_unit (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .cur_secure(cur_secure),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_fault(csr_fault), .exc_req(exc_req),
        .exc_type(exc_type), .exc_target(exc_target), .exc_class(exc_class),
        .exc_iss(exc_iss), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .vec_mode(vec_mode), .syndrome(syndrome)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // access right from the requirements R6..R9
    function automatic bit perm(logic [1:0] md, logic sec, logic [1:0] sel);
        case (sel)
            2'd0: return md != 2'd0;                  // R8
            2'd1: return md == 2'd2 || md == 2'd3;    // R7
            2'd2: return md == 2'd3;                  // R6
            default: return sec && (md == 2'd1 || md == 2'd3); // R9
        endcase
    endfunction

    // target mode from R3, R4, R5
    function automatic logic [1:0] exp_mode(logic [1:0] md, logic sec, logic [2:0] ty, logic [1:0] tg);
        if (ty == 3'd5 && m_ve && md == 2'd1 && !sec) return 2'd2;
        if (tg == 2'd3) return 2'd3;
        if (tg == 2'd2 && m_ve) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [31:0] exp_addr(logic [1:0] md, logic sec, logic [2:0] ty, logic [1:0] tg);
        logic [1:0] nm;
        logic [31:0] off;
        nm = exp_mode(md, sec, ty, tg);
        if (ty == 3'd5) off = (nm == 2'd2 && tg != 2'd2) || (md == 2'd1 && !sec && m_ve) ? 32'h14 : 32'h04;
        else off = {27'd0, ty, 2'b00};
        case (nm)
            2'd2: return m_base[1] + off;
            2'd3: return m_base[2] + off;
            default: return m_base[0] + off;
        endcase
    endfunction

    // one cycle: inputs already driven at a negedge
    task automatic cycle(string tag);
        bit          acc, ok, hyp, hvc;
        logic [31:0] e_rd, e_addr;
        logic [1:0]  e_mode;
        acc = csr_wr || csr_rd;
        ok  = perm(cur_mode, cur_secure, csr_sel);
        e_rd = 32'd0;
        if (csr_rd && ok) e_rd = (csr_sel == 2'd3) ? {31'd0, m_ve} : m_base[csr_sel];
        e_mode = exp_mode(cur_mode, cur_secure, exc_type, exc_target);
        e_addr = exp_addr(cur_mode, cur_secure, exc_type, exc_target);
        hyp = exc_req && e_mode == 2'd2;
        hvc = exc_type == 3'd5 && m_ve && cur_mode == 2'd1 && !cur_secure;
        @(posedge clk); #1;
        if (csr_wr && ok) begin
            if (csr_sel == 2'd3) m_ve = csr_wdata[0];
            else m_base[csr_sel] = {csr_wdata[31:5], 5'd0};  // R11
        end
        if (hyp) m_syn = {hvc ? 6'h12 : exc_class, exc_iss};
        chk({tag, " R10 fault"}, {31'd0, csr_fault}, {31'd0, acc && !ok});
        chk({tag, " R10 rdata"}, csr_rdata, e_rd);
        chk({tag, " R2 valid"}, {31'd0, vec_valid}, {31'd0, exc_req});
        if (exc_req) begin
            chk({tag, " R2 R3 R4 R5 addr"}, vec_addr, e_addr);
            chk({tag, " R5 mode"}, {30'd0, vec_mode}, {30'd0, e_mode});
        end
        chk({tag, " R12 syndrome"}, syndrome, m_syn);
        @(negedge clk);
        csr_wr = 0; csr_rd = 0; exc_req = 0;
    endtask

    task automatic set_mode(logic [1:0] md, logic sec);
        cur_mode = md; cur_secure = sec;
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d, string tag);
        csr_wr = 1; csr_sel = sel; csr_wdata = d; cycle(tag);
    endtask

    task automatic rd(logic [1:0] sel, string tag);
        csr_rd = 1; csr_sel = sel; cycle(tag);
    endtask

    task automatic exc(logic [2:0] ty, logic [1:0] tg, string tag);
        exc_req = 1; exc_type = ty; exc_target = tg;
        exc_class = 6'($urandom); exc_iss = 26'($urandom);
        cycle(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 3; i++) m_base[i] = 32'd0;
        m_ve = 0; m_syn = 32'd0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state (still in reset)
        chk("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
        chk("R1 fault", {31'd0, csr_fault}, 32'd0);
        chk("R1 rdata", csr_rdata, 32'd0);
        chk("R1 syndrome", syndrome, 32'd0);
        @(negedge clk); rst_n = 1;
        set_mode(2'd3, 1'b1);
        rd(2'd0, "R1 guest");
        rd(2'd1, "R1 hyp");
        rd(2'd2, "R1 mon");
        rd(2'd3, "R1 ctl");
        // R11 alignment
        wr(2'd2, 32'hFFFF_FFFF, "R11 mon");
        rd(2'd2, "R11 mon readback");
        wr(2'd1, 32'h8000_1237, "R11 hyp");
        wr(2'd0, 32'h0000_4021, "R11 guest");
        // R2 all offsets, virtualization off
        set_mode(2'd0, 1'b0);
        for (int t = 0; t < 8; t++) exc(3'(t), 2'd1, "R2 offset");
        // R4 hvc with virt off, R5 hyp target with virt off
        set_mode(2'd1, 1'b0);
        exc(3'd5, 2'd1, "R4 hvc off");
        exc(3'd3, 2'd2, "R5 hyp target off");
        // R9 denied from non-secure kernel, then allowed from secure kernel
        wr(2'd3, 32'd1, "R9 ns denied");
        rd(2'd3, "R9 readback");
        set_mode(2'd1, 1'b1);
        wr(2'd3, 32'd1, "R9 secure ok");
        rd(2'd3, "R9 readback on");
        // R3 hvc from non-secure kernel
        set_mode(2'd1, 1'b0);
        exc(3'd5, 2'd3, "R3 hvc");
        exc(3'd2, 2'd0, "R12 hold");
        set_mode(2'd1, 1'b1);
        exc(3'd5, 2'd1, "R4 hvc secure");
        set_mode(2'd0, 1'b0);
        exc(3'd5, 2'd1, "R4 hvc user");
        // R6 R7 R8 denied writes
        set_mode(2'd2, 1'b0);
        wr(2'd2, 32'h1111_1100, "R6 hyp on mon");
        rd(2'd2, "R6 hyp read mon");
        set_mode(2'd1, 1'b0);
        wr(2'd1, 32'h2222_2200, "R7 kern on hyp");
        set_mode(2'd0, 1'b0);
        wr(2'd0, 32'h3333_3300, "R8 user on guest");
        set_mode(2'd3, 1'b1);
        rd(2'd1, "R7 readback");
        rd(2'd0, "R8 readback");
        exc(3'd6, 2'd2, "R5 hyp target on");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] md;
            logic sec;
            int k;
            md = 2'($urandom);
            sec = (md == 2'd3) ? 1'b1 : (md == 2'd2) ? 1'b0 : 1'($urandom);
            set_mode(md, sec);
            k = $urandom % 4;
            if (k == 0) wr(2'($urandom), (($urandom % 8) == 0) ? 32'd0 : $urandom, "R10 rand wr");
            else if (k == 1) rd(2'($urandom), "R10 rand rd");
            else if (k == 2) exc(3'($urandom), 2'($urandom), "R2 rand exc");
            else cycle("R12 rand idle");
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule